// File: doc/BRIEF.md
# Edge-Aligned PWM Generator with Cycle-by-Cycle Trip

This block produces an edge-aligned pulse-width-modulated output for peak-current-mode power stages. An up-counting time base runs from zero to a programmable terminal count and wraps. The output rises at the start of every period and falls when the count reaches a compare value. A digitized over-current flag from an external comparator ends the pulse early by setting a latch that holds the output low for the rest of that period. The latch releases itself when the next period begins.

Right after a period starts, switching noise can make the comparator flag look active even when there is no fault. To stop this from ending the pulse, the trip is ignored inside a programmable blanking window that is placed relative to the start of each period. The terminal count, compare value and blanking settings are taken from the inputs only at the period boundary. A controller can therefore update them at any time without producing a torn period.

Top module: `pwm_trip_top`

## Requirements
- R1: With terminal count P, a period lasts exactly P+1 clock cycles. `prd_start_o` is high for one cycle per period, on the first cycle in which the output shows the new period.
- R2: With compare value C where 0 < C < P and no trip, the output is high for the first C cycles of each period and low for the remaining cycles. The output rises only in the cycle where `prd_start_o` is high.
- R3: If C is greater than or equal to P, the output stays high for the whole period. If C is 0, the output stays low for the whole period.
- R4: Terminal count, compare and blanking inputs are sampled only at the wrap from P to zero. A change made in the middle of a period does not alter that period.
- R5: While reset is high, `pwm_o`, `trip_latched_o` and `prd_start_o` are low after the next clock edge and the counter is zero. The first period after reset uses the built-in defaults: terminal count 500, compare 250, blanking offset 0 and blanking width 30. This gives a 501-cycle period with 250 high cycles.
- R6: A trip that passes the two-stage synchronizer while enabled and not blanked sets `trip_latched_o`. The output is then held low until the next period starts, even if `trip_i` has already dropped. A single-cycle pulse on `trip_i`, driven while the counter holds value k, takes effect on the output three cycles later.
- R7: A trip is ignored while the counter value lies in the range [offset, offset+width). With offset 0, width W and `trip_i` held high, each period's pulse is min(C, W) cycles long.
- R8: While `trip_en_i` is low, `trip_i` has no effect on `pwm_o` or `trip_latched_o`.
- R9: The latch clears when the counter is zero. If the trip is still present and count zero lies outside the blanking window (offset above 0, or width 0), the latch sets again at once. In that case the period has no high cycles and `trip_latched_o` is high in the cycle where `prd_start_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| period_i | input | CNT_W | Terminal count P, sampled at wrap |
| cmp_i | input | CNT_W | Compare value C, sampled at wrap |
| blank_ofs_i | input | CNT_W | Blanking window start count, sampled at wrap |
| blank_wid_i | input | CNT_W | Blanking window length in counts, sampled at wrap |
| trip_i | input | 1 | Asynchronous comparator trip flag, active high |
| trip_en_i | input | 1 | Enables the trip path |
| pwm_o | output | 1 | Registered PWM output |
| trip_latched_o | output | 1 | Cycle-by-cycle trip latch state |
| prd_start_o | output | 1 | One-cycle strobe at the start of each period |

## Verification
The assertions assume that reset is held for at least one clock edge before any checking starts. They also assume that the active terminal count is never so large that the counter increment would overflow CNT_W bits. The bench keeps the terminal count at or below 500 and applies reset at time zero. It holds `trip_i` at a constant level across each measured period, except in the directed test that uses a single pulse. It changes settings only at clock falling edges, so the synchronizer never sees an input change at a rising edge.

// File: rtl/pwm_trip_pkg.sv
package pwm_trip_pkg;

  localparam int CNT_W_DEF   = 16;
  localparam int PER_DEF     = 500;
  localparam int CMP_DEF     = 250;
  localparam int BLK_OFS_DEF = 0;
  localparam int BLK_WID_DEF = 30;
  localparam int SYNC_DEF    = 2;

  // Edge action that the compare logic requests for the output.
  typedef enum logic [1:0] {
    ACT_HOLD = 2'd0,
    ACT_SET  = 2'd1,
    ACT_CLR  = 2'd2
  } edge_act_e;

endpackage

// File: rtl/pwm_timebase.sv
module pwm_timebase #(
  parameter int CNT_W   = 16,
  parameter int PER_DEF = 500,
  parameter int CMP_DEF = 250,
  parameter int OFS_DEF = 0,
  parameter int WID_DEF = 30
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] period_i,
  input  logic [CNT_W-1:0] cmp_i,
  input  logic [CNT_W-1:0] ofs_i,
  input  logic [CNT_W-1:0] wid_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             at_zero_o,
  output logic [CNT_W-1:0] act_per_o,
  output logic [CNT_W-1:0] act_cmp_o,
  output logic [CNT_W-1:0] act_ofs_o,
  output logic [CNT_W-1:0] act_wid_o
);

  localparam logic [CNT_W-1:0] PER_RST = CNT_W'(PER_DEF);
  localparam logic [CNT_W-1:0] CMP_RST = CNT_W'(CMP_DEF);
  localparam logic [CNT_W-1:0] OFS_RST = CNT_W'(OFS_DEF);
  localparam logic [CNT_W-1:0] WID_RST = CNT_W'(WID_DEF);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] per_q, cmp_q, ofs_q, wid_q;
  logic             wrap;

  assign wrap = (cnt_q >= per_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      per_q <= PER_RST;
      cmp_q <= CMP_RST;
      ofs_q <= OFS_RST;
      wid_q <= WID_RST;
    end else if (wrap) begin
      // Shadow transfer happens only at the period boundary.
      cnt_q <= '0;
      per_q <= period_i;
      cmp_q <= cmp_i;
      ofs_q <= ofs_i;
      wid_q <= wid_i;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign cnt_o     = cnt_q;
  assign at_zero_o = (cnt_q == '0);
  assign act_per_o = per_q;
  assign act_cmp_o = cmp_q;
  assign act_ofs_o = ofs_q;
  assign act_wid_o = wid_q;

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (rst)
    (cnt_q != '0) |-> (cnt_q == CNT_W'($past(cnt_q) + 1'b1))); // R1

  AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (rst)
    (cnt_q != '0) |-> ($stable(per_q) && $stable(cmp_q) && $stable(ofs_q) && $stable(wid_q))); // R4

endmodule

// File: rtl/pwm_trip_sync.sv
module pwm_trip_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_i,
  output logic sync_o
);

  logic [STAGES-1:0] sr_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) sr_q <= '0;
        else     sr_q <= async_i;
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (rst) sr_q <= '0;
        else     sr_q <= {sr_q[STAGES-2:0], async_i};
      end
    end
  endgenerate

  assign sync_o = sr_q[STAGES-1];

endmodule

// File: rtl/pwm_blank_win.sv
module pwm_blank_win #(
  parameter int CNT_W = 16
) (
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] ofs_i,
  input  logic [CNT_W-1:0] wid_i,
  output logic             blank_o
);

  localparam int EW = CNT_W + 1;

  logic [EW-1:0] lo_e, hi_e, cnt_e;

  always_comb begin
    cnt_e   = {1'b0, cnt_i};
    lo_e    = {1'b0, ofs_i};
    hi_e    = {1'b0, ofs_i} + {1'b0, wid_i};
    blank_o = (cnt_e >= lo_e) && (cnt_e < hi_e);
  end

endmodule

// File: rtl/pwm_trip_out.sv
module pwm_trip_out
  import pwm_trip_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             at_zero_i,
  input  logic [CNT_W-1:0] act_per_i,
  input  logic [CNT_W-1:0] act_cmp_i,
  input  logic             blank_i,
  input  logic             trip_s_i,
  input  logic             trip_en_i,
  output logic             pwm_o,
  output logic             latch_o,
  output logic             strobe_o
);

  logic      pwm_q, latch_q, strobe_q;
  logic      qual_trip, latch_d, pwm_d, cmp_hit;
  edge_act_e act;

  always_comb begin
    qual_trip = trip_en_i && trip_s_i && !blank_i;
    // Set beats clear: a trip at count zero re-arms the latch at once.
    latch_d   = qual_trip || (latch_q && !at_zero_i);
    cmp_hit   = (cnt_i == act_cmp_i) && (act_cmp_i < act_per_i);
    if (cmp_hit)        act = ACT_CLR;
    else if (at_zero_i) act = ACT_SET;
    else                act = ACT_HOLD;
    if (latch_d) pwm_d = 1'b0;
    else begin
      case (act)
        ACT_SET: pwm_d = 1'b1;
        ACT_CLR: pwm_d = 1'b0;
        default: pwm_d = pwm_q;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pwm_q    <= 1'b0;
      latch_q  <= 1'b0;
      strobe_q <= 1'b0;
    end else begin
      pwm_q    <= pwm_d;
      latch_q  <= latch_d;
      strobe_q <= at_zero_i;
    end
  end

  assign pwm_o    = pwm_q;
  assign latch_o  = latch_q;
  assign strobe_o = strobe_q;

  AST_TRIP_FORCES_LOW: assert property (@(posedge clk) disable iff (rst)
    latch_q |-> !pwm_q); // R6

  AST_LATCH_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (latch_q && !at_zero_i) |=> latch_q); // R6

  AST_RISE_AT_START: assert property (@(posedge clk) disable iff (rst)
    $rose(pwm_q) |-> strobe_q); // R2

  AST_SET_NEEDS_QUAL: assert property (@(posedge clk) disable iff (rst)
    $rose(latch_q) |-> $past(trip_en_i && trip_s_i && !blank_i)); // R7

endmodule

// File: rtl/pwm_trip_top.sv
module pwm_trip_top
  import pwm_trip_pkg::*;
#(
  parameter int CNT_W   = CNT_W_DEF,
  parameter int PER_INI = PER_DEF,
  parameter int CMP_INI = CMP_DEF,
  parameter int OFS_INI = BLK_OFS_DEF,
  parameter int WID_INI = BLK_WID_DEF,
  parameter int SYNC_N  = SYNC_DEF
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] period_i,
  input  logic [CNT_W-1:0] cmp_i,
  input  logic [CNT_W-1:0] blank_ofs_i,
  input  logic [CNT_W-1:0] blank_wid_i,
  input  logic             trip_i,
  input  logic             trip_en_i,
  output logic             pwm_o,
  output logic             trip_latched_o,
  output logic             prd_start_o
);

  logic [CNT_W-1:0] cnt, act_per, act_cmp, act_ofs, act_wid;
  logic             at_zero, trip_s, blank;

  pwm_timebase #(
    .CNT_W(CNT_W), .PER_DEF(PER_INI), .CMP_DEF(CMP_INI),
    .OFS_DEF(OFS_INI), .WID_DEF(WID_INI)
  ) u_tb (
    .clk(clk), .rst(rst),
    .period_i(period_i), .cmp_i(cmp_i), .ofs_i(blank_ofs_i), .wid_i(blank_wid_i),
    .cnt_o(cnt), .at_zero_o(at_zero),
    .act_per_o(act_per), .act_cmp_o(act_cmp), .act_ofs_o(act_ofs), .act_wid_o(act_wid)
  );

  pwm_trip_sync #(.STAGES(SYNC_N)) u_sync (
    .clk(clk), .rst(rst), .async_i(trip_i), .sync_o(trip_s)
  );

  pwm_blank_win #(.CNT_W(CNT_W)) u_blank (
    .cnt_i(cnt), .ofs_i(act_ofs), .wid_i(act_wid), .blank_o(blank)
  );

  pwm_trip_out #(.CNT_W(CNT_W)) u_out (
    .clk(clk), .rst(rst),
    .cnt_i(cnt), .at_zero_i(at_zero), .act_per_i(act_per), .act_cmp_i(act_cmp),
    .blank_i(blank), .trip_s_i(trip_s), .trip_en_i(trip_en_i),
    .pwm_o(pwm_o), .latch_o(trip_latched_o), .strobe_o(prd_start_o)
  );

  AST_NO_TRIP_WHEN_OFF: assert property (@(posedge clk) disable iff (rst)
    (!trip_en_i && !trip_latched_o) |=> !trip_latched_o); // R8

endmodule

// File: tb/tb_pwm_trip_top.sv
module tb_pwm_trip_top;

  localparam int CLK_PERIOD = 10;
  localparam int W = 16;

  typedef struct packed {
    logic [W-1:0] per;
    logic [W-1:0] cmp;
    logic [W-1:0] ofs;
    logic [W-1:0] wid;
    logic         en;
    logic         trip;
    logic [W-1:0] hi;
    logic         st0;
    logic [3:0]   req;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VECS [NV] = '{
    '{16'd40, 16'd20, 16'd0, 16'd5,  1'b0, 1'b0, 16'd20, 1'b0, 4'd2}, // R2
    '{16'd63, 16'd10, 16'd0, 16'd5,  1'b0, 1'b0, 16'd10, 1'b0, 4'd2}, // R2
    '{16'd40, 16'd40, 16'd0, 16'd5,  1'b0, 1'b0, 16'd41, 1'b0, 4'd3}, // R3
    '{16'd40, 16'd55, 16'd0, 16'd5,  1'b0, 1'b0, 16'd41, 1'b0, 4'd3}, // R3
    '{16'd40, 16'd0,  16'd0, 16'd5,  1'b0, 1'b0, 16'd0,  1'b0, 4'd3}, // R3
    '{16'd40, 16'd20, 16'd0, 16'd5,  1'b1, 1'b1, 16'd5,  1'b0, 4'd6}, // R6
    '{16'd40, 16'd20, 16'd0, 16'd30, 1'b1, 1'b1, 16'd20, 1'b0, 4'd7}, // R7
    '{16'd40, 16'd20, 16'd0, 16'd5,  1'b0, 1'b1, 16'd20, 1'b0, 4'd8}, // R8
    '{16'd40, 16'd20, 16'd3, 16'd5,  1'b1, 1'b1, 16'd0,  1'b1, 4'd9}, // R9
    '{16'd40, 16'd20, 16'd0, 16'd0,  1'b1, 1'b1, 16'd0,  1'b1, 4'd9}, // R9
    '{16'd20, 16'd19, 16'd0, 16'd8,  1'b1, 1'b1, 16'd8,  1'b0, 4'd7}  // R7
  };

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] period_i = 16'd40, cmp_i = 16'd20, blank_ofs_i = '0, blank_wid_i = 16'd5;
  logic         trip_i = 1'b0, trip_en_i = 1'b0;
  logic         pwm_o, trip_latched_o, prd_start_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwm_trip_top dut (
    .clk(clk), .rst(rst),
    .period_i(period_i), .cmp_i(cmp_i), .blank_ofs_i(blank_ofs_i), .blank_wid_i(blank_wid_i),
    .trip_i(trip_i), .trip_en_i(trip_en_i),
    .pwm_o(pwm_o), .trip_latched_o(trip_latched_o), .prd_start_o(prd_start_o)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic wait_strobe();
    do @(negedge clk); while (!prd_start_o);
  endtask

  // Called at a strobe sample; counts through to the next strobe sample.
  task automatic measure(output int hi, output int len, output int st0);
    hi = 0; len = 0; st0 = int'(trip_latched_o);
    do begin
      if (pwm_o) hi++;
      len++;
      @(negedge clk);
    end while (!prd_start_o);
  endtask

  initial begin
    int hi, len, st0;
    // R5: reset state
    repeat (3) @(negedge clk);
    check("R5", "pwm in reset", int'(pwm_o), 0);
    check("R5", "latch in reset", int'(trip_latched_o), 0);
    check("R5", "strobe in reset", int'(prd_start_o), 0);
    rst = 1'b0;
    // R5: first period uses defaults, R1 strobe on first cycle
    @(negedge clk);
    check("R1", "strobe after release", int'(prd_start_o), 1);
    measure(hi, len, st0);
    check("R5", "default period length", len, 501);
    check("R5", "default high count", hi, 250);

    // Vector table
    for (int i = 0; i < NV; i++) begin
      period_i = VECS[i].per; cmp_i = VECS[i].cmp;
      blank_ofs_i = VECS[i].ofs; blank_wid_i = VECS[i].wid;
      trip_en_i = VECS[i].en; trip_i = VECS[i].trip;
      wait_strobe(); wait_strobe();
      measure(hi, len, st0);
      check($sformatf("R%0d", VECS[i].req), "high count", hi, int'(VECS[i].hi));
      check("R1", "period length", len, int'(VECS[i].per) + 1);
      check($sformatf("R%0d", VECS[i].req), "latch at start", st0, int'(VECS[i].st0));
    end

    // R4: mid-period change does not alter the running period
    trip_i = 1'b0; trip_en_i = 1'b0;
    period_i = 16'd40; cmp_i = 16'd20; blank_ofs_i = '0; blank_wid_i = 16'd5;
    wait_strobe(); wait_strobe();
    cmp_i = 16'd35; period_i = 16'd50;
    measure(hi, len, st0);
    check("R4", "old compare held", hi, 20);
    check("R4", "old period held", len, 41);
    measure(hi, len, st0);
    check("R4", "new compare applied", hi, 35);
    check("R4", "new period applied", len, 51);

    // R6: one-cycle trip pulse latches until next period
    period_i = 16'd40; cmp_i = 16'd30; trip_en_i = 1'b1;
    wait_strobe(); wait_strobe();
    hi = 0; len = 0;
    for (int k = 0; k < 41; k++) begin
      if (pwm_o) hi++;
      if (k == 10) trip_i = 1'b1;
      if (k == 11) trip_i = 1'b0;
      if (k == 20) check("R6", "latch held after pulse", int'(trip_latched_o), 1);
      @(negedge clk);
    end
    // trip driven at sample 10: two sync stages plus latch give 13 high samples
    check("R6", "pulse-shortened high count", hi, 13);
    check("R6", "latch cleared at new period", int'(trip_latched_o), 0);
    measure(hi, len, st0);
    check("R6", "normal pulse after clear", hi, 30);

    // R5: reset asserted mid-run
    wait_strobe();
    repeat (3) @(negedge clk);
    check("R2", "high early in period", int'(pwm_o), 1);
    rst = 1'b1;
    @(negedge clk);
    check("R5", "pwm low after reset", int'(pwm_o), 0);
    check("R5", "strobe low after reset", int'(prd_start_o), 0);
    check("R5", "latch low after reset", int'(trip_latched_o), 0);
    rst = 1'b0;

    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule